// File: doc/BRIEF.md
# Hyperframe service-interrupt indication relay

This block carries one service-interrupt flag across a serial link. The flag travels in a single bit of a control byte that occurs once per hyperframe. On the link that bit is bit 2 of the byte. The block handles only that bit position. Framing, line coding and the other bits of the control byte belong to the surrounding logic.

On the transmit side, local logic raises `sdi_raise` for one cycle or longer. The block remembers the request and drives `tx_ind_bit` high at the next transmit slot. The surrounding framer marks that slot with `tx_slot`, which is high in the cycle that carries bit 2 of the control byte. Outside the slot, `tx_ind_bit` is 0.

On the receive side, the deframer marks the same bit position with `rx_slot` and presents its value on `rx_ind_bit`. Each slot sets `sdi_req` to the value of the received bit. The request then holds for the whole hyperframe until the next slot check. A flag that repeats in every hyperframe therefore gives a continuous request. A request that stops clears it after one hyperframe.

There is no data stream and no back-pressure. All pins are plain control pins.

Top module: `sdi_relay`

## Requirements
- R1: `tx_ind_bit` is 0 in every cycle where `tx_slot` is 0, even while a request is pending.
- R2: In a cycle where `tx_slot` is 1 and nothing is pending, `tx_ind_bit` is 0.
- R3: A one-cycle `sdi_raise` pulse that arrives before a slot sets `tx_ind_bit` to 1 in the next slot, and only in that slot: the slot after it carries 0.
- R4: An `sdi_raise` pulse that arrives in the same cycle as `tx_slot` is carried in that slot.
- R5: While `sdi_raise` is held high, every slot carries 1.
- R6: After a slot where `rx_ind_bit` is 1, `sdi_req` is 1 from the next cycle on.
- R7: Between receive slots, `sdi_req` keeps its value.
- R8: After a slot where `rx_ind_bit` is 0, `sdi_req` is 0 from the next cycle on.
- R9: Reset clears the pending request, and `sdi_req` is 0 while reset is active. After reset is released, a slot with no new request carries 0.
- R10: One `sdi_raise` pulse per hyperframe, each a few cycles ahead of its slot, makes every slot carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi_raise | input | 1 | Local service-interrupt request, either a pulse or a level |
| tx_slot | input | 1 | High in the cycle that carries the indication bit of the outgoing control byte |
| tx_ind_bit | output | 1 | Indication bit value to send; meaningful only while `tx_slot` is high |
| rx_slot | input | 1 | High in the cycle that carries the indication bit of the incoming control byte |
| rx_ind_bit | input | 1 | Received indication bit; sampled when `rx_slot` is high |
| sdi_req | output | 1 | Received service-interrupt request, held from one slot check to the next |

## Verification
The transmit side is tested with four input patterns:
- A single early pulse, which shows that the request is latched and then released after one slot.
- A pulse in the same cycle as the slot, which shows the pass-through path.
- A held level, which shows that the flag repeats in every slot.
- Pulses repeated a few cycles before each slot.

The receive side is tested with:
- Bit sequences 1,1,0, which show the rise of the request, its refresh, and its fall.
- Toggling of `rx_ind_bit` outside the slots, which must have no effect on `sdi_req`.

A request left pending when reset is applied shows that reset clears it.

// File: rtl/sdi_relay_pkg.sv
package sdi_relay_pkg;
  // Bit position of the indication inside the hyperframe control byte.
  localparam int unsigned SDI_BIT_POS = 2;
  // Width of the control byte that carries the indication.
  localparam int unsigned CTRL_BYTE_W = 8;
  typedef logic [CTRL_BYTE_W-1:0] ctrl_byte_t;
endpackage

// File: rtl/sdi_tx_pend.sv
module sdi_tx_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic slot_i,
  output logic bit_o
);
  logic pend_q;

  // The flag is cleared once the slot has gone out. A level that is still
  // high sets it again in the next cycle, so a held request repeats.
  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (slot_i) pend_q <= 1'b0;
    else if (raise_i) pend_q <= 1'b1;
  end

  // A raise in the slot cycle itself passes straight through.
  always_comb bit_o = slot_i & (pend_q | raise_i);
endmodule

// File: rtl/sdi_rx_hold.sv
module sdi_rx_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_i,
  input  logic bit_i,
  output logic req_o
);
  logic req_q;

  // Sampled once per hyperframe and held until the next slot check.
  always_ff @(posedge clk) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (slot_i) req_q <= bit_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/sdi_relay.sv
module sdi_relay
  import sdi_relay_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sdi_raise,
  input  logic tx_slot,
  output logic tx_ind_bit,
  input  logic rx_slot,
  input  logic rx_ind_bit,
  output logic sdi_req
);
  sdi_tx_pend u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise_i (sdi_raise),
    .slot_i  (tx_slot),
    .bit_o   (tx_ind_bit)
  );

  sdi_rx_hold u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_i (rx_slot),
    .bit_i  (rx_ind_bit),
    .req_o  (sdi_req)
  );
endmodule

// File: rtl/sdi_relay_chk.sv
module sdi_relay_chk (
  input logic clk,
  input logic rst_n,
  input logic sdi_raise,
  input logic tx_slot,
  input logic tx_ind_bit,
  input logic rx_slot,
  input logic rx_ind_bit,
  input logic sdi_req
);
  p_quiet_off_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_slot |-> !tx_ind_bit);

  p_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot && sdi_raise) |-> tx_ind_bit);

  p_rx_sample_r6_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot |=> (sdi_req == $past(rx_ind_bit)));

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_slot |=> $stable(sdi_req));

  p_early_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdi_raise && !tx_slot) |=> (tx_slot -> tx_ind_bit));

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> !sdi_req);
endmodule

bind sdi_relay sdi_relay_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdi_raise  (sdi_raise),
  .tx_slot    (tx_slot),
  .tx_ind_bit (tx_ind_bit),
  .rx_slot    (rx_slot),
  .rx_ind_bit (rx_ind_bit),
  .sdi_req    (sdi_req)
);

// File: tb/sdi_relay_tb.sv
`timescale 1ns/1ps
module sdi_relay_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi_raise = 1'b0;
  logic tx_slot = 1'b0;
  logic tx_ind_bit;
  logic rx_slot = 1'b0;
  logic rx_ind_bit = 1'b0;
  logic sdi_req;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdi_relay dut_i (
    .clk(clk), .rst_n(rst_n), .sdi_raise(sdi_raise), .tx_slot(tx_slot),
    .tx_ind_bit(tx_ind_bit), .rx_slot(rx_slot), .rx_ind_bit(rx_ind_bit),
    .sdi_req(sdi_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive all inputs at the falling edge, then let combinational paths settle.
  task automatic step(input logic ts, input logic ra, input logic rs, input logic rb);
    @(negedge clk);
    tx_slot = ts; sdi_raise = ra; rx_slot = rs; rx_ind_bit = rb;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    check("R9 req in reset", sdi_req, 1'b0);
    rst_n = 1'b1;
    step(1, 0, 0, 0);
    check("R9 slot after reset", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_idle_slot;
    step(1, 0, 0, 0);
    check("R2 idle slot", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_early_pulse;
    step(0, 1, 0, 0);
    check("R1 pulse off slot", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
    check("R1 pending off slot", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R3 next slot set", tx_ind_bit, 1'b1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R3 later slot clear", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_same_cycle;
    step(1, 1, 0, 0);
    check("R4 same-cycle pulse", tx_ind_bit, 1'b1);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R4 not repeated", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_level;
    for (int h = 0; h < 4; h++) begin
      step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      step(1, 1, 0, 0);
      check("R5 held level slot", tx_ind_bit, 1'b1);
    end
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R5 after release", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_periodic;
    for (int h = 0; h < 3; h++) begin
      step(0, 0, 0, 0);
      step(0, 1, 0, 0);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      step(1, 0, 0, 0);
      check("R10 periodic pulse slot", tx_ind_bit, 1'b1);
    end
    step(0, 0, 0, 0);
  endtask

  task automatic t_rx;
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    check("R6 req rises", sdi_req, 1'b1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R7 hold high", sdi_req, 1'b1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    check("R6 refresh", sdi_req, 1'b1);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    check("R8 req falls", sdi_req, 1'b0);
    step(0, 0, 0, 1);
    check("R7 hold low", sdi_req, 1'b0);
  endtask

  task automatic t_reset_pending;
    step(0, 1, 1, 1);
    step(0, 0, 0, 0);
    rst_n = 1'b0;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check("R9 req cleared", sdi_req, 1'b0);
    rst_n = 1'b1;
    step(1, 0, 0, 0);
    check("R9 pending cleared", tx_ind_bit, 1'b0);
    step(0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_idle_slot();
    t_early_pulse();
    t_same_cycle();
    t_level();
    t_periodic();
    t_rx();
    t_reset_pending();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule